// File: doc/BRIEF.md
# Multicore Boot Release Table

This block is a memory-mapped table of boot records, one per processor core, that lets the primary core start secondary cores. Each record is 32 bytes long and is organised as eight 32-bit words. Word 0 and word 1 hold the 64-bit start address, with word 1 carrying the least significant half. Words 2 and 3 hold the 64-bit argument, with word 3 carrying the least significant half. Word 4 is reserved. Word 5 holds the processor identifier. Words 6 and 7 are reserved. Bit 0 of the start address acts as a hold flag: while it is 1, the core keeps waiting.

Software reaches the table through a simple request/response port. Each access moves 1, 2 or 4 bytes, and bytes are ordered big-endian. Whenever an accepted write leaves the hold flag of a record at 0, the block produces a one-cycle release pulse for that core. The pulse comes with a registered payload that the core start-up logic consumes:
- the entry offset inside a 64 MiB window;
- the window base;
- the window size;
- the argument word.

At the moment of release, the record's identifier word is replaced with the hardware identifier of that core.

The primary core, index 0, never waits in the table. Its record is therefore read-only. Records at or beyond the number of present cores are also read-only.

Top module: `boot_release_table`

## Requirements
- R1: After reset, record i holds start address 1 (word 1 = 1, word 0 = 0), argument i (word 3 = i, word 2 = 0) and processor identifier i (word 5 = i). Every other word holds zero. `err_flag` and `rel_pulse` are low.
- R2: A read of `req_size` bytes (1, 2 or 4) at byte address A returns the addressed bytes big-endian and zero-extended in `rsp_rdata`, with `rsp_valid` high in the next cycle. Address bits below the access size are ignored, so accesses are taken as naturally aligned. Byte address A lies in record A/32 at byte offset A%32.
- R3: A write changes only the addressed bytes of the table; every other byte keeps its value.
- R4: A write to record 0 or to a record index at or above `NUM_PRESENT` changes nothing and causes no release.
- R5: When an accepted write leaves bit 0 of the record's start address at 0, `rel_pulse` is high for exactly one cycle on the next clock, and only the bit of that core is set. In the same cycle the payload is presented as follows:
  - `rel_entry` is the address masked to its low 26 bits;
  - `rel_base` is the address with those 26 bits cleared;
  - `rel_size` is 2^26;
  - `rel_arg` is the record's 64-bit argument.
- R6: Every accepted write to a record whose hold flag stays at 0 pulses again, including writes to fields other than the address.
- R7: On a release, word 5 of the released record is loaded with that core's 32-bit field of `core_hwid`, the slice at bits [32*i +: 32].
- R8: An access whose `req_size` is not 1, 2 or 4 sets `err_flag`, which stays set until reset. Such an access leaves the table unchanged and causes no release. A read of this kind returns zero.
- R9: An accepted write that leaves bit 0 of the start address at 1 causes no release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address in the table |
| req_size | input | 3 | Access width in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| core_hwid | input | 32*NUM_SLOTS | Hardware identifier of each core |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, zero-extended |
| err_flag | output | 1 | Sticky illegal-width flag |
| rel_pulse | output | NUM_SLOTS | One-hot release pulse |
| rel_entry | output | 64 | Entry offset inside the window |
| rel_base | output | 64 | Window base address |
| rel_size | output | 64 | Window size |
| rel_arg | output | 64 | Argument handed to the core |

## Verification
The bench builds the block with the full 32-record table and `NUM_PRESENT` set to 6. With these values, the bench can write to records that exist in the address map but belong to absent cores, and confirm that such writes are ignored. The bench also reads back all 256 words of the table after reset. It then starts several cores using full-word, half-word and single-byte writes, so that releases are triggered from different byte lanes.

// File: rtl/bootrel_pkg.sv
package bootrel_pkg;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned REC_WORDS  = 8;
  localparam int unsigned REC_BYTES  = REC_WORDS * WORD_BYTES;

  localparam logic [2:0] WIX_ADDR_HI = 3'd0;
  localparam logic [2:0] WIX_ADDR_LO = 3'd1;
  localparam logic [2:0] WIX_ARG_HI  = 3'd2;
  localparam logic [2:0] WIX_ARG_LO  = 3'd3;
  localparam logic [2:0] WIX_PID     = 3'd5;

  typedef struct packed {
    logic [3:0]  be;
    logic [31:0] data;
  } lane_t;

  function automatic logic size_legal(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [31:0] merge_word(input logic [31:0] old, input lane_t ln);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{ln.be[b]}};
    return (old & ~m) | (ln.data & m);
  endfunction

  function automatic logic [31:0] read_lane(input logic [31:0] word, input logic [2:0] sz,
                                            input logic [1:0] off);
    logic [4:0] sh;
    sh = {2'd3 - off, 3'b000};
    case (sz)
      3'd1:    return (word >> sh) & 32'h0000_00FF;
      3'd2:    return off[1] ? {16'd0, word[15:0]} : {16'd0, word[31:16]};
      3'd4:    return word;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] rec_reset_word(input int unsigned idx);
    int unsigned s;
    logic [2:0]  w;
    s = idx / REC_WORDS;
    w = 3'(idx % REC_WORDS);
    case (w)
      WIX_ADDR_LO:         return 32'd1;
      WIX_ARG_LO, WIX_PID: return 32'(s);
      default:             return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/boot_bus_port.sv
module boot_bus_port
  import bootrel_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       rd_word,
  output logic              wr_req,
  output logic [ADDR_W-3:0] word_ix,
  output lane_t             wr_lane,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              err_flag
);

  logic        acc_ok;
  logic [1:0]  off;
  logic        rsp_valid_d;
  logic [31:0] rsp_rdata_d;
  logic        err_d;
  logic        rsp_en;

  assign word_ix = req_addr[ADDR_W-1:2];

  // Lane decode: data is replicated, byte enables pick the big-endian lanes
  always_comb begin
    acc_ok = size_legal(req_size);
    case (req_size)
      3'd1: begin
        off          = req_addr[1:0];
        wr_lane.be   = 4'b1000 >> off;
        wr_lane.data = {4{req_wdata[7:0]}};
      end
      3'd2: begin
        off          = {req_addr[1], 1'b0};
        wr_lane.be   = req_addr[1] ? 4'b0011 : 4'b1100;
        wr_lane.data = {2{req_wdata[15:0]}};
      end
      3'd4: begin
        off          = 2'd0;
        wr_lane.be   = 4'b1111;
        wr_lane.data = req_wdata;
      end
      default: begin
        off          = 2'd0;
        wr_lane.be   = 4'b0000;
        wr_lane.data = 32'd0;
      end
    endcase
    wr_req = req_valid && req_write && acc_ok;
  end

  // Response next state
  always_comb begin
    rsp_valid_d = req_valid && !req_write;
    rsp_en      = rsp_valid_d;
    rsp_rdata_d = acc_ok ? read_lane(rd_word, req_size, off) : 32'd0;
    err_d       = err_flag || (req_valid && !acc_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
      err_flag  <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      err_flag  <= err_d;
      if (rsp_en) rsp_rdata <= rsp_rdata_d;
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

endmodule

// File: rtl/boot_rec_store.sv
module boot_rec_store
  import bootrel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 32,
  parameter int unsigned NUM_PRESENT = 32,
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS),
  localparam int unsigned WIX_W      = SLOT_W + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_req,
  input  logic [WIX_W-1:0]       word_ix,
  input  lane_t                  wr_lane,
  input  logic                   pid_load,
  input  logic [32*NUM_SLOTS-1:0] core_hwid,
  output logic [31:0]            rd_word,
  output logic                   wr_acc,
  output logic [SLOT_W-1:0]      slot,
  output logic [63:0]            post_addr,
  output logic [63:0]            post_arg
);

  localparam int unsigned NUM_WORDS   = NUM_SLOTS * REC_WORDS;
  localparam logic [SLOT_W:0] PRESENT_LIM = (SLOT_W+1)'(NUM_PRESENT);

  logic [31:0] mem_q [NUM_WORDS];
  logic [31:0] mem_d [NUM_WORDS];
  logic [31:0] post_w [4];
  logic        tbl_en;

  assign slot    = word_ix[WIX_W-1:3];
  assign rd_word = mem_q[word_ix];

  // Write acceptance: core 0 and absent cores are read-only
  always_comb begin
    wr_acc = wr_req && (slot != '0) && ({1'b0, slot} < PRESENT_LIM);
  end

  // Look-ahead of the addressed record's address and argument after the write
  always_comb begin
    for (int j = 0; j < 4; j++) begin
      post_w[j] = mem_q[{slot, 3'(j)}];
      if (wr_acc && (word_ix[2:0] == 3'(j))) post_w[j] = merge_word(post_w[j], wr_lane);
    end
    post_addr = {post_w[WIX_ADDR_HI], post_w[WIX_ADDR_LO]};
    post_arg  = {post_w[WIX_ARG_HI], post_w[WIX_ARG_LO]};
  end

  // Table next state: byte-lane merge, then identifier load on release
  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) mem_d[i] = mem_q[i];
    if (wr_acc) mem_d[word_ix] = merge_word(mem_q[word_ix], wr_lane);
    if (pid_load) mem_d[{slot, WIX_PID}] = core_hwid[32*slot +: 32];
    tbl_en = wr_acc || pid_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= rec_reset_word(i);
    end else if (tbl_en) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  assert_core0_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && slot == '0) |=> $stable(mem_q[1]));

endmodule

// File: rtl/boot_rel_launch.sv
module boot_rel_launch #(
  parameter int unsigned NUM_SLOTS = 32,
  parameter int unsigned WIN_BITS  = 26,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [63:0]          addr,
  input  logic [63:0]          arg,
  output logic [NUM_SLOTS-1:0] rel_pulse,
  output logic [63:0]          rel_entry,
  output logic [63:0]          rel_base,
  output logic [63:0]          rel_size,
  output logic [63:0]          rel_arg
);

  localparam logic [63:0] WIN_SPAN = 64'd1 << WIN_BITS;
  localparam logic [63:0] WIN_MASK = WIN_SPAN - 64'd1;

  logic [NUM_SLOTS-1:0] pulse_d;
  logic [63:0]          entry_d, base_d;
  logic                 pay_en;

  always_comb begin
    pulse_d       = '0;
    pulse_d[slot] = go;
    pay_en        = go;
    entry_d       = addr & WIN_MASK;
    base_d        = addr & ~WIN_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_pulse <= '0;
      rel_entry <= 64'd0;
      rel_base  <= 64'd0;
      rel_arg   <= 64'd0;
    end else begin
      rel_pulse <= pulse_d;
      if (pay_en) begin
        rel_entry <= entry_d;
        rel_base  <= base_d;
        rel_arg   <= arg;
      end
    end
  end

  assign rel_size = WIN_SPAN;

  assert_pulse_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_pulse));

  assert_window_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ((rel_entry | rel_base) == $past(addr)));

endmodule

// File: rtl/boot_release_table.sv
module boot_release_table
  import bootrel_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 32,
  parameter int unsigned NUM_PRESENT = 32,
  parameter int unsigned WIN_BITS    = 26,
  localparam int unsigned ADDR_W     = $clog2(NUM_SLOTS * REC_BYTES),
  localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [2:0]              req_size,
  input  logic [31:0]             req_wdata,
  input  logic [32*NUM_SLOTS-1:0] core_hwid,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    err_flag,
  output logic [NUM_SLOTS-1:0]    rel_pulse,
  output logic [63:0]             rel_entry,
  output logic [63:0]             rel_base,
  output logic [63:0]             rel_size,
  output logic [63:0]             rel_arg
);

  logic              wr_req;
  logic [ADDR_W-3:0] word_ix;
  lane_t             wr_lane;
  logic [31:0]       rd_word;
  logic              wr_acc;
  logic [SLOT_W-1:0] slot;
  logic [63:0]       post_addr;
  logic [63:0]       post_arg;
  logic              rel_go;

  boot_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rd_word(rd_word),
    .wr_req(wr_req), .word_ix(word_ix), .wr_lane(wr_lane),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .err_flag(err_flag)
  );

  boot_rec_store #(.NUM_SLOTS(NUM_SLOTS), .NUM_PRESENT(NUM_PRESENT)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_req(wr_req), .word_ix(word_ix), .wr_lane(wr_lane),
    .pid_load(rel_go), .core_hwid(core_hwid),
    .rd_word(rd_word), .wr_acc(wr_acc), .slot(slot),
    .post_addr(post_addr), .post_arg(post_arg)
  );

  // Hold flag is bit 0 of the start address after the write is merged
  assign rel_go = wr_acc && !post_addr[0];

  boot_rel_launch #(.NUM_SLOTS(NUM_SLOTS), .WIN_BITS(WIN_BITS)) u_launch (
    .clk(clk), .rst_n(rst_n),
    .go(rel_go), .slot(slot), .addr(post_addr), .arg(post_arg),
    .rel_pulse(rel_pulse), .rel_entry(rel_entry), .rel_base(rel_base),
    .rel_size(rel_size), .rel_arg(rel_arg)
  );

  assert_no_primary_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_pulse[0]);

  assert_bad_size_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !size_legal(req_size)) |=> (rel_pulse == '0));

endmodule

// File: tb/tb_boot_release_table.sv
module tb_boot_release_table;

  localparam int NS = 32;
  localparam int NP = 6;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_write;
  logic [9:0]      req_addr;
  logic [2:0]      req_size;
  logic [31:0]     req_wdata;
  logic [32*NS-1:0] core_hwid;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic            err_flag;
  logic [NS-1:0]   rel_pulse;
  logic [63:0]     rel_entry, rel_base, rel_size, rel_arg;

  boot_release_table #(.NUM_SLOTS(NS), .NUM_PRESENT(NP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .core_hwid(core_hwid), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .err_flag(err_flag), .rel_pulse(rel_pulse), .rel_entry(rel_entry),
    .rel_base(rel_base), .rel_size(rel_size), .rel_arg(rel_arg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] data;
    string       tag;
  } rd_item_t;

  typedef struct {
    int          due;
    int          core;
    logic [63:0] entry;
    logic [63:0] base;
    logic [63:0] arg;
    string       tag;
  } rel_item_t;

  rd_item_t  rd_q[$];
  rel_item_t rel_q[$];
  logic [7:0] mdl [1024];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit err_exp = 1'b0;
  bit mon_on  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] hwid_of(input int i);
    return 32'h00A0_0000 + 32'(i * 17);
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mdl_q64(input int a);
    logic [63:0] v = 64'd0;
    for (int k = 0; k < 8; k++) v = {v[55:0], mdl[a+k]};
    return v;
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < 1024; i++) mdl[i] = 8'h00;
    for (int r = 0; r < NS; r++) begin
      mdl[r*32 + 7]  = 8'h01;
      mdl[r*32 + 15] = 8'(r);
      mdl[r*32 + 23] = 8'(r);
    end
  endtask

  // Driver: one access, expectations pushed for the monitor
  task automatic acc(input bit wr, input int addr, input int sz, input logic [31:0] d,
                     input string tag);
    bit legal;
    int a, rec;
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr[9:0];
    req_size = sz[2:0]; req_wdata = d;
    legal = (sz == 1) || (sz == 2) || (sz == 4);
    if (!legal) err_exp = 1'b1;
    a = legal ? (addr & ~(sz - 1)) : addr;
    rec = a / 32;
    if (!wr) begin
      v = 32'd0;
      if (legal) for (int k = 0; k < sz; k++) v = {v[23:0], mdl[a+k]};
      rd_q.push_back('{due: cyc + 1, data: v, tag: tag});
    end else if (legal && rec != 0 && rec < NP) begin
      for (int k = 0; k < sz; k++) mdl[a+k] = 8'(d >> (8 * (sz - 1 - k)));
      if (mdl[rec*32 + 7][0] == 1'b0) begin
        logic [63:0] ad;
        ad = mdl_q64(rec*32);
        rel_q.push_back('{due: cyc + 1, core: rec, entry: ad & 64'h3FF_FFFF,
                          base: ad & ~64'h3FF_FFFF, arg: mdl_q64(rec*32 + 8), tag: tag});
        for (int k = 0; k < 4; k++) mdl[rec*32 + 20 + k] = 8'(hwid_of(rec) >> (8 * (3 - k)));
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: pops expectations in the cycle they are due
  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_q.size() != 0 && rd_q[0].due == cyc) begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(it.tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(it.tag, "rsp_rdata", 64'(rsp_rdata), 64'(it.data));
      end else if (rsp_valid) begin
        chk("R2", "unexpected rsp_valid", 64'd1, 64'd0);
      end
      if (rel_q.size() != 0 && rel_q[0].due == cyc) begin
        rel_item_t it;
        logic [NS-1:0] oh;
        it = rel_q.pop_front();
        oh = '0;
        oh[it.core] = 1'b1;
        chk(it.tag, "rel_pulse", 64'(rel_pulse), 64'(oh));
        chk(it.tag, "rel_entry", rel_entry, it.entry);
        chk(it.tag, "rel_base", rel_base, it.base);
        chk(it.tag, "rel_size", rel_size, 64'h0000_0000_0400_0000);
        chk(it.tag, "rel_arg", rel_arg, it.arg);
      end else if (rel_pulse != '0) begin
        chk("R4/R9", "unexpected release", 64'(rel_pulse), 64'd0);
      end
    end
  end

  task automatic read_record(input int rec, input string tag);
    for (int w = 0; w < 8; w++) acc(1'b0, rec*32 + w*4, 4, 32'd0, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NS; i++) core_hwid[32*i +: 32] = hwid_of(i);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 3'd4; req_wdata = '0;
    rst_n = 1'b0;
    mdl_reset();
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "err_flag", 64'(err_flag), 64'd0);
    chk("R1", "rel_pulse", 64'(rel_pulse), 64'd0);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R1: every reset word of the table
    for (int r = 0; r < NS; r++) read_record(r, "R1");

    // R2: narrow big-endian reads with zero extension
    acc(1'b0, 3*32 + 15, 1, 32'd0, "R2");
    acc(1'b0, 3*32 + 14, 2, 32'd0, "R2");
    acc(1'b0, 3*32 + 7, 1, 32'd0, "R2");
    acc(1'b0, 3*32 + 21, 1, 32'd0, "R2");

    // R3: single-byte write merges into one lane
    acc(1'b1, 2*32 + 9, 1, 32'h0000_00C5, "R3");
    read_record(2, "R3");
    acc(1'b1, 2*32 + 18, 2, 32'h0000_BEEF, "R3");
    read_record(2, "R3");

    // R4: primary core and absent cores are read-only
    acc(1'b1, 0*32 + 4, 4, 32'h0000_0000, "R4");
    read_record(0, "R4");
    acc(1'b1, 7*32 + 4, 4, 32'h1234_5670, "R4");
    acc(1'b1, 31*32 + 7, 1, 32'h0000_0000, "R4");
    read_record(7, "R4");
    read_record(31, "R4");

    // R9: address writes that keep the hold flag set
    acc(1'b1, 2*32 + 0, 4, 32'h0000_0001, "R9");
    acc(1'b1, 2*32 + 4, 4, 32'h0ABC_DEF1, "R9");

    // R5 R7: release core 2 and check the identifier update
    acc(1'b1, 2*32 + 4, 4, 32'h1ABC_DEF0, "R5");
    read_record(2, "R7");

    // R6: a later write on a released record pulses again
    acc(1'b1, 2*32 + 12, 2, 32'h0000_7788, "R6");
    acc(1'b1, 2*32 + 28, 4, 32'hFFFF_0000, "R6");
    read_record(2, "R6");

    // R5: release core 3 through one byte lane
    acc(1'b1, 3*32 + 0, 2, 32'h0000_0002, "R5");
    acc(1'b1, 3*32 + 7, 1, 32'h0000_0040, "R5");
    read_record(3, "R7");

    // R5: release core 5 with a full-word write at the window edge
    acc(1'b1, 5*32 + 4, 4, 32'hFBFF_FFFE, "R5");

    // R8: illegal widths
    acc(1'b1, 4*32 + 4, 3, 32'h0000_0000, "R8");
    @(negedge clk);
    chk("R8", "err_flag", 64'(err_flag), 64'(err_exp));
    acc(1'b0, 4*32 + 4, 0, 32'd0, "R8");
    read_record(4, "R8");
    acc(1'b0, 4*32 + 4, 4, 32'd0, "R8");
    @(negedge clk);
    chk("R8", "err_flag sticky", 64'(err_flag), 64'd1);

    // R9: setting the hold flag again stops further releases
    acc(1'b1, 2*32 + 7, 1, 32'h0000_0001, "R9");
    acc(1'b1, 2*32 + 8, 4, 32'h0000_0042, "R9");
    read_record(2, "R9");

    repeat (4) @(negedge clk);
    chk("R2", "pending reads", 64'(rd_q.size()), 64'd0);
    chk("R5", "pending releases", 64'(rel_q.size()), 64'd0);
    finish_run();
  end

endmodule